// File: doc/BRIEF.md
# Two-Deep Receive Status Register

This block holds the receive status of one OUT endpoint in a full-speed USB device function and shows it to firmware as one 8-bit word. The receive engine sends a single-cycle completion event at the end of each packet. The event carries the packet's error flag, whether it was a SETUP, the data PID toggle, the isochronous mode flag and the FIFO byte count. The block turns each event into a status word. Firmware reads the word with a one-cycle read strobe.

A single status register would lose information when a zero-length OUT packet is followed at once by a SETUP packet with data. To prevent this, the block keeps two status copies as a small queue. The first read returns the older status. The second read returns the newer one. Each read clears the flag bits. The byte count is kept, so an idle word still shows how many bytes the FIFO holds.

Top module: `rx_stat_dual`

## Requirements
- R1: Two completion events that arrive before any read are queued. The first read returns the first event's status word, and the second event's word becomes visible on the following cycle.
- R2: The count field shows the event's FIFO byte count, limited to 15. Any count above 15 reads as 4'hF.
- R3: A read strobe returns the status word as it stands in that cycle. On the next cycle, with no second copy queued, bits 7..4 read 0 and bits 3..0 keep their count.
- R4: Receive-last (bit 4) is set for every completion in ISO mode. Outside ISO mode it is set only when the packet had no error, meaning it was acknowledged.
- R5: The toggle bit (bit 5) is 0 for a DATA0 packet and 1 for a DATA1 packet.
- R6: The word layout is: bit 7 receive error, bit 6 SETUP, bit 5 toggle, bit 4 receive-last, bits 3..0 count.
- R7: After reset the status word is 8'h00.
- R8: If a third event arrives while both copies hold unread status, it replaces the newer copy. The older copy is kept.
- R9: When a read strobe and a completion event fall in the same cycle, the read pops first and then the event is stored. With one copy held, the new word becomes visible. With two held, the second copy becomes visible and the new word is queued behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Packet completion pulse |
| evt_err | input | 1 | Packet ended in error |
| evt_setup | input | 1 | Packet was a SETUP |
| evt_toggle | input | 1 | Data PID toggle (0 = DATA0, 1 = DATA1) |
| evt_iso | input | 1 | Endpoint is in isochronous mode |
| evt_bytes | input | FIFO_CNT_W | Bytes in receive FIFO |
| rd_stb | input | 1 | Firmware read strobe, one cycle |
| status | output | 8 | Visible status word |

## Verification
The firmware read and the receive engine's completion event can land in the same cycle. This is the coincidence the bench targets. Both pulses are driven on the same falling edge, once with one copy held and once with both copies held. The word seen afterwards is compared against R9: the new event must be visible, or the second copy must be visible with the new event surfacing on the following read. In either case no status may be lost or cleared by mistake.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
   localparam int STAT_W    = 8;
   localparam int CNT_FLD_W = 4;
   localparam int CNT_MAX   = (1 << CNT_FLD_W) - 1;

   typedef struct packed {
      logic                 err;
      logic                 setup;
      logic                 tog;
      logic                 last;
      logic [CNT_FLD_W-1:0] cnt;
   } rx_word_t;
endpackage

// File: rtl/rx_stat_fmt.sv
module rx_stat_fmt
   import rx_stat_pkg::*;
#(
   parameter int FIFO_CNT_W = 7,
   parameter bit ISO_EN     = 1'b1
) (
   input  logic                  err,
   input  logic                  setup,
   input  logic                  tog,
   input  logic                  iso,
   input  logic [FIFO_CNT_W-1:0] bytes,
   output rx_word_t              word
);
   localparam int WIDE = (FIFO_CNT_W > CNT_FLD_W) ? 1 : 0;

   logic                 last_c;
   logic [CNT_FLD_W-1:0] cnt_c;

   if (FIFO_CNT_W < 1) begin : g_bad_w
      $error("FIFO_CNT_W must be at least 1");
   end

   if (WIDE == 1) begin : g_sat
      always_comb begin
         if (bytes > FIFO_CNT_W'(CNT_MAX)) cnt_c = CNT_FLD_W'(CNT_MAX);
         else                              cnt_c = bytes[CNT_FLD_W-1:0];
      end
   end else begin : g_narrow
      assign cnt_c = CNT_FLD_W'(bytes);
   end

   if (ISO_EN) begin : g_iso
      assign last_c = iso | ~err;
   end else begin : g_noiso
      logic unused_iso;
      assign unused_iso = iso;
      assign last_c     = ~err;
   end

   always_comb begin
      word.err   = err;
      word.setup = setup;
      word.tog   = tog;
      word.last  = last_c;
      word.cnt   = cnt_c;
   end
endmodule

// File: rtl/rx_stat_queue.sv
module rx_stat_queue
   import rx_stat_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     push,
   input  rx_word_t push_word,
   input  logic     pop,
   output rx_word_t head,
   output logic     head_full,
   output logic     tail_full
);
   rx_word_t slot0, slot1;
   logic     full0, full1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot0 <= '0;
         slot1 <= '0;
         full0 <= 1'b0;
         full1 <= 1'b0;
      end else if (pop && full1) begin
         slot0 <= slot1;
         full0 <= 1'b1;
         if (push) begin
            slot1 <= push_word;
            full1 <= 1'b1;
         end else begin
            full1 <= 1'b0;
         end
      end else if (pop) begin
         if (push) begin
            slot0 <= push_word;
            full0 <= 1'b1;
         end else begin
            slot0.err   <= 1'b0;
            slot0.setup <= 1'b0;
            slot0.tog   <= 1'b0;
            slot0.last  <= 1'b0;
            full0       <= 1'b0;
         end
      end else if (push) begin
         if (full0) begin
            slot1 <= push_word;
            full1 <= 1'b1;
         end else begin
            slot0 <= push_word;
            full0 <= 1'b1;
         end
      end
   end

   assign head      = slot0;
   assign head_full = full0;
   assign tail_full = full1;

   AST_POP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      pop && full1 |=> slot0 == $past(slot1)); // R1
   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !full0 |-> (!slot0.err && !slot0.setup && !slot0.tog && !slot0.last)); // R3
   AST_TAIL_NEEDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      full1 |-> full0); // R1
   AST_NEWEST_REPLACED: assert property (@(posedge clk) disable iff (!rst_n)
      push && !pop && full1 |=> full1 && slot1 == $past(push_word) && $stable(slot0)); // R8
   AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      push && pop && !full1 |=> full0 && slot0 == $past(push_word)); // R9
endmodule

// File: rtl/rx_stat_dual.sv
module rx_stat_dual
   import rx_stat_pkg::*;
#(
   parameter int FIFO_CNT_W = 7,
   parameter bit ISO_EN     = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  evt_valid,
   input  logic                  evt_err,
   input  logic                  evt_setup,
   input  logic                  evt_toggle,
   input  logic                  evt_iso,
   input  logic [FIFO_CNT_W-1:0] evt_bytes,
   input  logic                  rd_stb,
   output logic [STAT_W-1:0]     status
);
   rx_word_t new_word, head;
   logic     head_full, tail_full;

   if ($bits(rx_word_t) != STAT_W) begin : g_bad_layout
      $error("status word layout must be STAT_W bits");
   end

   rx_stat_fmt #(.FIFO_CNT_W(FIFO_CNT_W), .ISO_EN(ISO_EN)) fmt_i (
      .err   (evt_err),
      .setup (evt_setup),
      .tog   (evt_toggle),
      .iso   (evt_iso),
      .bytes (evt_bytes),
      .word  (new_word)
   );

   rx_stat_queue q_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (evt_valid),
      .push_word (new_word),
      .pop       (rd_stb),
      .head      (head),
      .head_full (head_full),
      .tail_full (tail_full)
   );

   assign status = head;

   AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && !head_full && (evt_bytes > FIFO_CNT_W'(CNT_MAX)) |=> status[3:0] == 4'hF); // R2
   AST_ERR_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && !head_full && !evt_iso && evt_err |=> status[7] && !status[4]); // R4
   AST_TOGGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && !head_full |=> status[5] == $past(evt_toggle)); // R5
   AST_FLAGS_NEED_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      !head_full |-> status[7:4] == 4'h0); // R7
endmodule

// File: tb/rx_stat_dual_tb.sv
module rx_stat_dual_tb_top;
   localparam int FW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          evt_valid = 1'b0, evt_err = 1'b0, evt_setup = 1'b0;
   logic          evt_toggle = 1'b0, evt_iso = 1'b0, rd_stb = 1'b0;
   logic [FW-1:0] evt_bytes = '0;
   logic [7:0]    status;
   int            checks = 0, errors = 0;
   bit            done = 1'b0;

   always #10 clk = ~clk;

   rx_stat_dual #(.FIFO_CNT_W(FW), .ISO_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_err(evt_err),
      .evt_setup(evt_setup), .evt_toggle(evt_toggle), .evt_iso(evt_iso),
      .evt_bytes(evt_bytes), .rd_stb(rd_stb), .status(status)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%02h exp=%02h", req, got, exp);
      end
   endtask

   task automatic set_evt(input logic e, input logic s, input logic t, input logic iso,
                          input int n);
      evt_valid  = 1'b1;
      evt_err    = e;
      evt_setup  = s;
      evt_toggle = t;
      evt_iso    = iso;
      evt_bytes  = FW'(n);
   endtask

   task automatic clr_in();
      evt_valid = 1'b0; evt_err = 1'b0; evt_setup = 1'b0;
      evt_toggle = 1'b0; evt_iso = 1'b0; evt_bytes = '0; rd_stb = 1'b0;
   endtask

   task automatic ev(input logic e, input logic s, input logic t, input logic iso, input int n);
      set_evt(e, s, t, iso, n);
      @(negedge clk);
      clr_in();
   endtask

   task automatic rd(output logic [7:0] got);
      rd_stb = 1'b1;
      got = status;
      @(negedge clk);
      clr_in();
   endtask

   task automatic t_reset();
      chk("R7 reset word", status, 8'h00);
   endtask

   task automatic t_basic();
      logic [7:0] g;
      ev(1'b0, 1'b0, 1'b1, 1'b0, 5);
      chk("R5/R6 DATA1 good pkt", status, 8'h35);
      rd(g);
      chk("R3 read returns pre-clear", g, 8'h35);
      chk("R3 flags cleared count kept", status, 8'h05);
   endtask

   task automatic t_sat();
      logic [7:0] g;
      ev(1'b0, 1'b0, 1'b0, 1'b0, 40);
      chk("R2 count saturates", status, 8'h1F);
      rd(g);
      ev(1'b0, 1'b0, 1'b0, 1'b0, 15);
      chk("R2 count 15 exact", status, 8'h1F);
      rd(g);
      ev(1'b0, 1'b0, 1'b0, 1'b0, 16);
      chk("R2 count 16 saturates", status, 8'h1F);
      rd(g);
      chk("R3 idle after read", status, 8'h0F);
   endtask

   task automatic t_err_last();
      logic [7:0] g;
      ev(1'b1, 1'b0, 1'b0, 1'b0, 3);
      chk("R4 non-ISO error no last", status, 8'h83);
      rd(g);
      ev(1'b1, 1'b0, 1'b1, 1'b1, 9);
      chk("R4 ISO error still last", status, 8'hB9);
      rd(g);
      ev(1'b0, 1'b0, 1'b0, 1'b1, 2);
      chk("R4 ISO good last", status, 8'h12);
      rd(g);
   endtask

   task automatic t_zlp_setup();
      logic [7:0] g;
      ev(1'b0, 1'b0, 1'b1, 1'b0, 0);
      ev(1'b0, 1'b1, 1'b0, 1'b0, 8);
      chk("R1 zlp visible first", status, 8'h30);
      rd(g);
      chk("R1 first read zlp", g, 8'h30);
      chk("R1 setup visible next", status, 8'h58);
      rd(g);
      chk("R1 second read setup", g, 8'h58);
      chk("R3 idle after both", status, 8'h08);
   endtask

   task automatic t_overwrite();
      logic [7:0] g;
      ev(1'b0, 1'b0, 1'b0, 1'b0, 1);
      ev(1'b0, 1'b0, 1'b1, 1'b0, 2);
      ev(1'b1, 1'b0, 1'b0, 1'b0, 3);
      rd(g);
      chk("R8 oldest kept", g, 8'h11);
      rd(g);
      chk("R8 newest replaced", g, 8'h83);
      chk("R8 queue drained", status, 8'h03);
   endtask

   task automatic t_coincide();
      logic [7:0] g;
      ev(1'b0, 1'b0, 1'b0, 1'b0, 4);
      set_evt(1'b0, 1'b0, 1'b1, 1'b0, 6);
      rd(g);
      chk("R9 read value one copy", g, 8'h14);
      chk("R9 new event visible", status, 8'h36);
      ev(1'b1, 1'b0, 1'b0, 1'b0, 7);
      set_evt(1'b0, 1'b1, 1'b0, 1'b0, 8);
      rd(g);
      chk("R9 read value two copies", g, 8'h36);
      chk("R9 second copy visible", status, 8'h87);
      rd(g);
      chk("R9 queued new event", status, 8'h58);
      rd(g);
      chk("R9 queue drained", status, 8'h08);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_sat();
      t_err_last();
      t_zlp_setup();
      t_overwrite();
      t_coincide();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog got=hung exp=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule